// File: doc/BRIEF.md
# Thermal Threshold Monitor

A register-mapped watcher for up to three temperature sensor channels. Each channel receives a 12-bit raw conversion code from an external converter together with a per-channel sample strobe. The raw code falls as the die heats up, so every threshold test here is "code at or below limit". Each accepted sample, or each averaged group of samples when the filter is on, becomes the channel's stored result. That result is compared against a hot threshold that has a separate re-arm (hysteresis) code, and against a shutdown threshold.

Three kinds of event are latched into one sticky status word: alarm, shutdown and result-ready. Writing ones to that word clears the matching bits. The status word is gated by an enable word of the same layout and drives a single interrupt line. A free-running acquisition counter issues a conversion-start pulse every N+1 clocks while any channel is enabled. Software reaches everything through a plain 32-bit read/write port, and read data appears one cycle after the read strobe.

Top module: `thermal_monitor`

## Requirements
- R1: After reset every register reads zero, the interrupt is low and every channel's alarm is armed.
- R2: Each result is stored in the channel's data word at byte offset 0x80+4*ch (bits 11:0, upper bits zero); the word changes only when a new result is produced.
- R3: An armed channel raises its alarm status bit (bit ch) when a result is less than or equal to its hot threshold, held in bits 27:16 of the word at 0x50+4*ch, and becomes disarmed.
- R4: A disarmed channel raises no further alarm until one of its results is greater than or equal to its re-arm code (bits 11:0 of the same word); that result re-arms it.
- R5: Any result less than or equal to the shutdown threshold (bits 27:16 of the word at 0x60+4*ch) sets status bit 4+ch, which stays set whatever later results are.
- R6: Every stored result sets the ready status bit 8+ch.
- R7: The status word at 0x48 clears exactly the bits written as one; other bits keep their value, and a new event in the same cycle wins over the clear.
- R8: The interrupt is high exactly when some status bit and the bit at the same position of the enable word at 0x44 are both set.
- R9: A channel whose enable bit (bit ch of the control word at 0x40) is clear ignores its samples: its data word holds and it raises no event.
- R10: With filter word (0x70) bit 2 set, the result is the truncated mean of 2^(k+1) consecutive samples, with k in bits 1:0, and ready is raised only when that mean is stored; writing the filter word restarts accumulation.
- R11: The conversion-start output pulses once every N+1 clocks, where N is control bits 31:16, and stays low while no channel is enabled.
- R12: The threshold fields read back as written, and bits outside the defined fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_re_i |
| raw_i | input | 36 | Raw codes, channel ch in bits 12*ch+11:12*ch |
| smp_i | input | 3 | Per-channel sample strobe |
| conv_start_o | output | 1 | Conversion start pulse to the converter |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench tests the alarm exactly at the threshold code and then walks results through the dead band between the hot and re-arm codes. A design that compares strictly, or that re-arms on any result above the hot code, shows an extra or a missing alarm bit there. It clears single bits out of a mixed status word and checks that a shutdown bit stays set after the temperature recovers, which catches a status word that clears as a whole or that follows the level. It feeds a code that would alarm into a disabled channel. It checks that partial filter groups produce neither data nor ready, and that the mean of an odd sum is truncated. It also measures the start-pulse spacing, where an off-by-one counter shows a period of N or N+2.

// File: rtl/thmon_pkg.sv
package thmon_pkg;
  localparam int unsigned ALM_LSB = 0;
  localparam int unsigned SHT_LSB = 4;
  localparam int unsigned RDY_LSB = 8;
  localparam int unsigned STW     = 11;

  localparam int unsigned A_CTRL = 'h40;
  localparam int unsigned A_IEN  = 'h44;
  localparam int unsigned A_STAT = 'h48;
  localparam int unsigned A_ALM  = 'h50;
  localparam int unsigned A_SHT  = 'h60;
  localparam int unsigned A_FILT = 'h70;
  localparam int unsigned A_DATA = 'h80;

  typedef struct packed {
    logic alm;
    logic sht;
    logic rdy;
  } evt_t;
endpackage

// File: rtl/thmon_acq.sv
module thmon_acq #(
  parameter int unsigned ACQW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [ACQW-1:0] period_i,
  output logic            tick_o
);
  logic [ACQW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_ACQ_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || period_i == '0)); // R11
endmodule

// File: rtl/thmon_chan.sv
module thmon_chan
  import thmon_pkg::*;
#(
  parameter int unsigned DW = 12,
  localparam int unsigned FW = DW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          smp_i,
  input  logic [DW-1:0] raw_i,
  input  logic          filt_en_i,
  input  logic [1:0]    filt_k_i,
  input  logic          filt_clr_i,
  input  logic [DW-1:0] hot_i,
  input  logic [DW-1:0] hyst_i,
  input  logic [DW-1:0] shut_i,
  output logic [DW-1:0] data_o,
  output evt_t          evt_o
);
  logic [FW-1:0] acc_q;
  logic [3:0]    cnt_q;
  logic [DW-1:0] res_q;
  logic          res_vld_q;
  logic          armed_q;

  logic [FW-1:0] sum;
  logic [4:0]    nsmp;
  logic [3:0]    last;
  logic [2:0]    shamt;

  assign sum   = acc_q + FW'(raw_i);
  assign nsmp  = 5'd2 << filt_k_i;
  assign last  = 4'(nsmp - 5'd1);
  assign shamt = {1'b0, filt_k_i} + 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      res_q     <= '0;
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= 1'b0;
      if (!en_i || filt_clr_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (smp_i) begin
        if (!filt_en_i) begin
          res_q     <= raw_i;
          res_vld_q <= 1'b1;
        end else if (cnt_q >= last) begin
          res_q     <= DW'(sum >> shamt);
          res_vld_q <= 1'b1;
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= sum;
          cnt_q <= cnt_q + 4'd1;
        end
      end
    end
  end

  // code falls with temperature: at-or-below means hot
  always_comb begin
    evt_o.rdy = res_vld_q;
    evt_o.alm = res_vld_q && armed_q && (res_q <= hot_i);
    evt_o.sht = res_vld_q && (res_q <= shut_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else if (res_vld_q) begin
      if (armed_q && res_q <= hot_i)        armed_q <= 1'b0;
      else if (!armed_q && res_q >= hyst_i) armed_q <= 1'b1;
    end
  end

  assign data_o = res_q;

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !evt_o.rdy); // R9
  AST_ALARM_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.alm |=> !evt_o.alm); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_q |-> $stable(data_o)); // R2
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
  import thmon_pkg::*;
#(
  parameter int unsigned NCH  = 3,
  parameter int unsigned DW   = 12,
  parameter int unsigned AW   = 8,
  parameter int unsigned ACQW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NCH*DW-1:0] raw_i,
  input  logic [NCH-1:0]    smp_i,
  output logic              conv_start_o,
  output logic              irq_o
);
  localparam logic [STW-1:0] CH_M  = STW'((1 << NCH) - 1);
  localparam logic [STW-1:0] VALID = (CH_M << ALM_LSB) | (CH_M << SHT_LSB) | (CH_M << RDY_LSB);

  logic [NCH-1:0]  en_q;
  logic [ACQW-1:0] acq_q;
  logic [STW-1:0]  ien_q, stat_q, stat_set, stat_clr;
  logic            filt_en_q;
  logic [1:0]      filt_k_q;
  logic [DW-1:0]   hot_q  [NCH];
  logic [DW-1:0]   hyst_q [NCH];
  logic [DW-1:0]   shut_q [NCH];
  logic [DW-1:0]   data   [NCH];
  evt_t            evt    [NCH];
  logic [31:0]     rd_mux, rdata_q;
  logic            filt_clr;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned off);
    return a == AW'(off);
  endfunction

  assign filt_clr = bus_we_i && hit(bus_addr_i, A_FILT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      acq_q     <= '0;
      ien_q     <= '0;
      filt_en_q <= 1'b0;
      filt_k_q  <= '0;
      for (int c = 0; c < NCH; c++) begin
        hot_q[c]  <= '0;
        hyst_q[c] <= '0;
        shut_q[c] <= '0;
      end
    end else if (bus_we_i) begin
      if (hit(bus_addr_i, A_CTRL)) begin
        en_q  <= bus_wdata_i[NCH-1:0];
        acq_q <= bus_wdata_i[16 +: ACQW];
      end
      if (hit(bus_addr_i, A_IEN)) ien_q <= bus_wdata_i[STW-1:0] & VALID;
      if (filt_clr) begin
        filt_en_q <= bus_wdata_i[2];
        filt_k_q  <= bus_wdata_i[1:0];
      end
      for (int c = 0; c < NCH; c++) begin
        if (hit(bus_addr_i, A_ALM + 4*c)) begin
          hot_q[c]  <= bus_wdata_i[16 +: DW];
          hyst_q[c] <= bus_wdata_i[0 +: DW];
        end
        if (hit(bus_addr_i, A_SHT + 4*c)) shut_q[c] <= bus_wdata_i[16 +: DW];
      end
    end
  end

  thmon_acq #(.ACQW(ACQW)) u_acq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (|en_q),
    .period_i (acq_q),
    .tick_o   (conv_start_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    thmon_chan #(.DW(DW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_q[c]),
      .smp_i      (smp_i[c]),
      .raw_i      (raw_i[c*DW +: DW]),
      .filt_en_i  (filt_en_q),
      .filt_k_i   (filt_k_q),
      .filt_clr_i (filt_clr),
      .hot_i      (hot_q[c]),
      .hyst_i     (hyst_q[c]),
      .shut_i     (shut_q[c]),
      .data_o     (data[c]),
      .evt_o      (evt[c])
    );
  end

  always_comb begin
    stat_set = '0;
    for (int c = 0; c < NCH; c++) begin
      stat_set[ALM_LSB + c] = evt[c].alm;
      stat_set[SHT_LSB + c] = evt[c].sht;
      stat_set[RDY_LSB + c] = evt[c].rdy;
    end
    stat_clr = (bus_we_i && hit(bus_addr_i, A_STAT)) ? bus_wdata_i[STW-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr_i, A_CTRL)) rd_mux = (32'(acq_q) << 16) | 32'(en_q);
    if (hit(bus_addr_i, A_IEN))  rd_mux = 32'(ien_q);
    if (hit(bus_addr_i, A_STAT)) rd_mux = 32'(stat_q);
    if (hit(bus_addr_i, A_FILT)) rd_mux = {29'd0, filt_en_q, filt_k_q};
    for (int c = 0; c < NCH; c++) begin
      if (hit(bus_addr_i, A_ALM + 4*c))  rd_mux = (32'(hot_q[c]) << 16) | 32'(hyst_q[c]);
      if (hit(bus_addr_i, A_SHT + 4*c))  rd_mux = 32'(shut_q[c]) << 16;
      if (hit(bus_addr_i, A_DATA + 4*c)) rd_mux = 32'(data[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_re_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && hit(bus_addr_i, A_STAT)) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
  AST_IRQ_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R8
endmodule

// File: tb/thermal_monitor_test.sv
`timescale 1ns/1ps
module thermal_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [35:0] raw = '0;
  logic [2:0]  smp = '0;
  logic        conv, irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_issued = 1'b0;

  always #2 clk = ~clk;

  thermal_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .raw_i(raw), .smp_i(smp),
    .conv_start_o(conv), .irq_o(irq));

  always @(posedge clk) rd_issued <= re;

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (rd_issued && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic samp(input int ch, input logic [11:0] code);
    @(negedge clk); raw[ch*12 +: 12] = code; smp[ch] = 1'b1;
    @(negedge clk); smp[ch] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic period(output int n);
    int guard;
    guard = 0;
    n = 0;
    @(negedge clk);
    while (!conv && guard < 100) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!conv && n < 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(32'(irq), 0, "R1 irq");
    rd(8'h40, 0, "R1 ctrl");
    rd(8'h48, 0, "R1 status");
    rd(8'h80, 0, "R1 data0");
    rd(8'h50, 0, "R1 alarm0");

    wr(8'h40, 32'h0000_0007);
    wr(8'h50, 32'h0400_0600);
    wr(8'h60, 32'h0200_0000);
    rd(8'h50, 32'h0400_0600, "R12 alarm0");
    wr(8'h54, 32'hF000_F456);
    rd(8'h54, 32'h0000_0456, "R12 alarm1 mask");
    rd(8'h60, 32'h0200_0000, "R12 shut0");

    samp(0, 12'h700);
    rd(8'h80, 32'h700, "R2 data0");
    rd(8'h48, 32'h100, "R6 ready");
    wr(8'h48, 32'h100);
    rd(8'h48, 0, "R7 clear");

    samp(0, 12'h400);
    rd(8'h48, 32'h101, "R3 alarm at threshold");
    wr(8'h48, 32'h101);
    samp(0, 12'h300);
    rd(8'h48, 32'h100, "R4 no re-alarm");
    samp(0, 12'h5FF);
    rd(8'h48, 32'h100, "R4 dead band");
    samp(0, 12'h600);
    samp(0, 12'h3FF);
    rd(8'h48, 32'h101, "R4 rearmed alarm");
    wr(8'h48, 32'h101);

    samp(0, 12'h200);
    rd(8'h48, 32'h110, "R5 shutdown");
    samp(0, 12'h700);
    rd(8'h48, 32'h110, "R5 sticky");
    wr(8'h48, 32'h010);
    rd(8'h48, 32'h100, "R7 partial clear");

    chk(32'(irq), 0, "R8 no enable");
    wr(8'h44, 32'h001);
    chk(32'(irq), 0, "R8 other bit");
    wr(8'h44, 32'h100);
    chk(32'(irq), 1, "R8 enabled bit");
    wr(8'h48, 32'h100);
    chk(32'(irq), 0, "R8 cleared");

    samp(1, 12'h123);
    rd(8'h84, 32'h123, "R2 data1");
    rd(8'h48, 32'h200, "R6 ready1");
    wr(8'h48, 32'h200);
    wr(8'h44, 32'h777);
    wr(8'h40, 32'h0000_0005);
    samp(1, 12'h000);
    rd(8'h84, 32'h123, "R9 data hold");
    rd(8'h48, 0, "R9 no event");
    chk(32'(irq), 0, "R9 irq");

    wr(8'h70, 32'h4);
    samp(2, 12'h100);
    rd(8'h48, 0, "R10 partial group");
    rd(8'h88, 0, "R10 data not yet");
    samp(2, 12'h201);
    rd(8'h88, 32'h180, "R10 mean of 2");
    rd(8'h48, 32'h400, "R10 ready");
    chk(32'(irq), 1, "R8 irq from ready2");
    wr(8'h48, 32'h400);
    wr(8'h70, 32'h5);
    samp(2, 12'h010);
    samp(2, 12'h020);
    samp(2, 12'h030);
    rd(8'h48, 0, "R10 three of four");
    samp(2, 12'h041);
    rd(8'h88, 32'h028, "R10 mean of 4");
    rd(8'h48, 32'h400, "R10 ready after 4");
    wr(8'h48, 32'h400);

    wr(8'h40, 32'h0003_0005);
    period(n);
    chk(32'(n), 4, "R11 period N+1");
    wr(8'h40, 32'h0003_0000);
    n = 0;
    repeat (20) begin @(negedge clk); if (conv) n++; end
    chk(32'(n), 0, "R11 idle");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule